// File: doc/BRIEF.md
# Configurable Dual Switch Channel Controller

This block holds the digital control for two output switch channels. Each channel drives one high-side and one low-side switch. Every channel has a data input and a configuration code, and the configuration code picks the switch set: push-pull, high-side only, low-side only, or parked. A global output enable and a fault-shutdown input gate all four switch commands. An inversion input flips the data of channel 1 only. Every slow input except the fault passes through a saturating-counter glitch filter before it is used. The enable, inversion, data and feedback inputs use one qualification length, and the configuration bits use a longer one.

A separate feedback path compares a filtered feedback input with a filtered polarity input. It requests an open-drain pull-low whenever the two differ. The switch commands are registered. A break-before-make rule keeps the two switches of a channel from ever being on together. The rule holds when the data flips and also when the configuration changes.

Top module: `dual_switch_ctrl`

## Requirements
- R1: While the filtered output enable is 0, all four switch commands are 0 on the next clock.
- R2: Configuration code 2'b00 (push-pull) turns on the high-side switch for filtered data 1 and the low-side switch for filtered data 0.
- R3: Configuration code 2'b10 (bit 1 = above-high detect) selects high-side only: the low-side switch stays off, and the high-side switch turns on only for data 1.
- R4: Configuration code 2'b01 (bit 0 = below-low detect) selects low-side only: the high-side switch stays off, and the low-side switch turns on only for data 1.
- R5: Configuration code 2'b11 parks the channel with both switches off.
- R6: When the filtered inversion input is 1, channel 1's data (index 0) is complemented before decoding. Channel 2 (index 1) is never inverted.
- R7: When fault_i is 1 at a clock edge, all four switch commands are 0 after that edge, whatever the other inputs are.
- R8: A switch of a channel is only turned on if the opposite switch of that channel was off in the previous cycle. A direct handover therefore passes through one cycle with both switches off, and both are never on at once.
- R9: fb_pull_o is 1 exactly when the filtered feedback input and the filtered polarity input differ.
- R10: The enable, inversion, data, feedback and polarity filters each change their output only after the raw input has held a new level for DATA_FLT consecutive clock samples. The switch commands follow one clock later.
- R11: Each configuration bit filter changes only after its raw bit has held a new level for CFG_FLT consecutive samples.
- R12: After reset, all filters read 0 and all switch commands and fb_pull_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Global output enable, raw |
| inv1_i | input | 1 | Channel 1 data inversion, raw |
| data_i | input | 2 | Channel data, index 0 = channel 1 |
| cfg_i | input | 4 | Configuration codes; bits [2n+1:2n] belong to channel n |
| fault_i | input | 1 | Fault shutdown, already synchronous |
| fb_in_i | input | 1 | Feedback comparator input, raw |
| fb_pol_i | input | 1 | Feedback polarity select, raw |
| hs_on_o | output | 2 | High-side switch commands |
| ls_on_o | output | 2 | Low-side switch commands |
| fb_pull_o | output | 1 | Feedback pull-low request |

## Verification
The bench targets pulses exactly one sample shorter than the qualification length and pulses of exactly that length. An off-by-one counter would let the short pulse through or swallow the full-length one. Push-pull data flips and configuration changes between high-only and low-only exercise the handover cycle. A design without break-before-make shows both switches on, or skips the dead cycle. Single-cycle fault pulses check that shutdown is taken at once and not through a filter. Toggling the inversion input while channel 2 holds its data exposes inversion leaking into the wrong channel.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    MODE_PUSH_PULL = 2'b00,
    MODE_LOW_ONLY  = 2'b01,
    MODE_HIGH_ONLY = 2'b10,
    MODE_PARKED    = 2'b11
  } sw_mode_e;
endpackage

// File: rtl/dsc_glitch_filter.sv
module dsc_glitch_filter #(
  parameter int unsigned QUAL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(QUAL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else if (raw_i == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(QUAL - 1)) begin
      filt_o <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsc_channel.sv
module dsc_channel
  import dsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       kill_i,
  input  logic       data_i,
  input  logic [1:0] mode_i,
  output logic       hs_o,
  output logic       ls_o
);
  sw_mode_e mode;
  logic want_hs, want_ls;

  always_comb begin
    mode    = sw_mode_e'(mode_i);
    want_hs = 1'b0;
    want_ls = 1'b0;
    unique case (mode)
      MODE_PUSH_PULL: begin
        want_hs = data_i;
        want_ls = ~data_i;
      end
      MODE_HIGH_ONLY: want_hs = data_i;
      MODE_LOW_ONLY:  want_ls = data_i;
      default: ;
    endcase
    if (!en_i || kill_i) begin
      want_hs = 1'b0;
      want_ls = 1'b0;
    end
  end

  // break-before-make: opposite switch must have been off last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else begin
      hs_o <= want_hs & ~ls_o;
      ls_o <= want_ls & ~hs_o;
    end
  end
endmodule

// File: rtl/dual_switch_ctrl.sv
module dual_switch_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned DATA_FLT = 16,
  parameter int unsigned CFG_FLT  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_i,
  input  logic              inv1_i,
  input  logic [NUM_CH-1:0] data_i,
  input  logic [2*NUM_CH-1:0] cfg_i,
  input  logic              fault_i,
  input  logic              fb_in_i,
  input  logic              fb_pol_i,
  output logic [NUM_CH-1:0] hs_on_o,
  output logic [NUM_CH-1:0] ls_on_o,
  output logic              fb_pull_o
);
  logic oe_filt, inv_filt, fb_in_filt, fb_pol_filt;

  dsc_glitch_filter #(.QUAL(DATA_FLT)) i_flt_oe (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(oe_i), .filt_o(oe_filt));
  dsc_glitch_filter #(.QUAL(DATA_FLT)) i_flt_inv (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(inv1_i), .filt_o(inv_filt));
  dsc_glitch_filter #(.QUAL(DATA_FLT)) i_flt_fbin (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(fb_in_i), .filt_o(fb_in_filt));
  dsc_glitch_filter #(.QUAL(DATA_FLT)) i_flt_fbpol (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(fb_pol_i), .filt_o(fb_pol_filt));

  assign fb_pull_o = fb_in_filt ^ fb_pol_filt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic       data_filt, data_eff;
    logic [1:0] cfg_filt;

    dsc_glitch_filter #(.QUAL(DATA_FLT)) i_flt_data (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(data_i[ch]), .filt_o(data_filt));

    for (genvar b = 0; b < 2; b++) begin : g_cfg
      dsc_glitch_filter #(.QUAL(CFG_FLT)) i_flt_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(cfg_i[2*ch+b]), .filt_o(cfg_filt[b]));
    end

    if (ch == 0) begin : g_inv
      assign data_eff = data_filt ^ inv_filt;
    end else begin : g_plain
      assign data_eff = data_filt;
    end

    dsc_channel i_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (oe_filt),
      .kill_i(fault_i),
      .data_i(data_eff),
      .mode_i(cfg_filt),
      .hs_o  (hs_on_o[ch]),
      .ls_o  (ls_on_o[ch])
    );
  end
endmodule

// File: rtl/dsc_checks.sv
module dsc_checks
  import dsc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_i,
  input logic              oe_f_i,
  input logic              fault_i,
  input logic [NUM_CH-1:0] hs_i,
  input logic [NUM_CH-1:0] ls_i
);
  p_fault_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (hs_i == '0 && ls_i == '0));

  p_enable_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_f_i |=> (hs_i == '0 && ls_i == '0));

  p_filter_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_f_i != $past(oe_f_i)) |-> (oe_f_i == $past(oe_i)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_i[ch] && ls_i[ch]));
    p_dead_cycle_hs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_i[ch]) |-> !$past(ls_i[ch]));
    p_dead_cycle_ls_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ls_i[ch]) |-> !$past(hs_i[ch]));
  end
endmodule

bind dual_switch_ctrl dsc_checks i_dsc_checks (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .oe_i   (oe_i),
  .oe_f_i (oe_filt),
  .fault_i(fault_i),
  .hs_i   (hs_on_o),
  .ls_i   (ls_on_o)
);

// File: tb/test_dual_switch_ctrl.sv
module test_dual_switch_ctrl;
  localparam int DF = 6;
  localparam int CF = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe = 1'b0, inv1 = 1'b0, fault = 1'b0, fb_in = 1'b0, fb_pol = 1'b0;
  logic [1:0] data = '0;
  logic [3:0] cfg = '0;
  logic [1:0] hs_on, ls_on;
  logic fb_pull;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R12";

  always #4 clk = ~clk;

  dual_switch_ctrl #(.DATA_FLT(DF), .CFG_FLT(CF)) i_dual_switch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .inv1_i(inv1), .data_i(data),
    .cfg_i(cfg), .fault_i(fault), .fb_in_i(fb_in), .fb_pol_i(fb_pol),
    .hs_on_o(hs_on), .ls_on_o(ls_on), .fb_pull_o(fb_pull));

  // reference model: index 0 oe, 1 inv, 2..3 data, 4 fb_in, 5 fb_pol, 6..9 cfg
  bit m_filt[10];
  int m_run[10];
  bit [1:0] m_hs = '0, m_ls = '0;

  function automatic int qual_of(int i);
    return (i >= 6) ? CF : DF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_filt[i]) begin m_filt[i] = 0; m_run[i] = 0; end
      m_hs = '0; m_ls = '0;
    end else begin
      bit raw[10];
      bit [1:0] nh, nl;
      raw[0] = oe; raw[1] = inv1; raw[2] = data[0]; raw[3] = data[1];
      raw[4] = fb_in; raw[5] = fb_pol;
      for (int i = 0; i < 4; i++) raw[6+i] = cfg[i];
      for (int c = 0; c < 2; c++) begin
        bit d, wh, wl;
        bit [1:0] md;
        d  = m_filt[2+c] ^ (c == 0 ? m_filt[1] : 1'b0);
        md = {m_filt[7+2*c], m_filt[6+2*c]};
        wh = 0; wl = 0;
        case (md)
          2'b00: begin wh = d; wl = !d; end
          2'b10: wh = d;
          2'b01: wl = d;
          default: ;
        endcase
        if (!m_filt[0] || fault) begin wh = 0; wl = 0; end
        nh[c] = wh && !m_ls[c];
        nl[c] = wl && !m_hs[c];
      end
      m_hs = nh; m_ls = nl;
      for (int i = 0; i < 10; i++) begin
        if (raw[i] != m_filt[i]) m_run[i]++; else m_run[i] = 0;
        if (m_run[i] == qual_of(i)) begin m_filt[i] = raw[i]; m_run[i] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_fb;
      exp_fb = m_filt[4] ^ m_filt[5];
      n_cmp++;
      if (hs_on !== m_hs) begin
        n_bad++;
        $display("FAIL %s hs_on actual=%b expected=%b t=%0t", cur_req, hs_on, m_hs, $time);
      end
      if (ls_on !== m_ls) begin
        n_bad++;
        $display("FAIL %s ls_on actual=%b expected=%b t=%0t", cur_req, ls_on, m_ls, $time);
      end
      if (fb_pull !== exp_fb) begin
        n_bad++;
        $display("FAIL %s fb_pull actual=%b expected=%b t=%0t", cur_req, fb_pull, exp_fb, $time);
      end
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    cur_req = "R12"; hold(4); rst_n = 1'b1; hold(3);
    // R1: data toggles with enable low
    cur_req = "R1";
    for (int k = 0; k < 4; k++) begin data = 2'(k); hold(DF + 3); end
    oe = 1'b1; hold(DF + 3);
    // R2 and R8: push-pull flips
    cur_req = "R2";
    for (int k = 0; k < 6; k++) begin data = ~data; hold(DF + 4); end
    // R3: high-side only on both channels
    cur_req = "R3"; cfg = 4'b1010; hold(CF + 3);
    for (int k = 0; k < 4; k++) begin data = 2'(k); hold(DF + 4); end
    // R8: swap high-only to low-only while data high
    cur_req = "R8"; data = 2'b11; hold(DF + 3);
    cfg = 4'b0101; hold(CF + 5); cfg = 4'b1010; hold(CF + 5);
    // R4: low-side only
    cur_req = "R4"; cfg = 4'b0101; hold(CF + 3);
    for (int k = 0; k < 4; k++) begin data = 2'(k); hold(DF + 4); end
    // R5: parked
    cur_req = "R5"; cfg = 4'b1111; hold(CF + 3);
    for (int k = 0; k < 4; k++) begin data = 2'(k); hold(DF + 4); end
    // R6: inversion on channel 1 only
    cur_req = "R6"; cfg = 4'b0000; data = 2'b10; hold(CF + 3);
    for (int k = 0; k < 4; k++) begin inv1 = ~inv1; hold(DF + 4); end
    // R7: fault pulses
    cur_req = "R7";
    fault = 1'b1; hold(1); fault = 1'b0; hold(5);
    fault = 1'b1; hold(7); fault = 1'b0; hold(6);
    // R9: feedback combinations
    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin {fb_in, fb_pol} = 2'(k); hold(DF + 3); end
    // R10: data and enable glitches at the boundary
    cur_req = "R10"; data = 2'b00; hold(DF + 3);
    data = 2'b11; hold(DF - 1); data = 2'b00; hold(DF + 3);
    data = 2'b11; hold(DF);     data = 2'b00; hold(DF + 3);
    oe = 1'b0; hold(DF - 1); oe = 1'b1; hold(DF + 3);
    oe = 1'b0; hold(DF);     oe = 1'b1; hold(DF + 3);
    // R11: configuration glitches at the boundary
    cur_req = "R11";
    cfg = 4'b1111; hold(CF - 1); cfg = 4'b0000; hold(CF + 3);
    cfg = 4'b1111; hold(CF);     cfg = 4'b0000; hold(CF + 4);
    // mixed random stimulus
    cur_req = "R10";
    for (int k = 0; k < 400; k++) begin
      oe = ($urandom_range(0, 7) != 0);
      inv1 = 1'($urandom); data = 2'($urandom); cfg = 4'($urandom);
      fb_in = 1'($urandom); fb_pol = 1'($urandom);
      fault = ($urandom_range(0, 15) == 0);
      hold($urandom_range(1, 30));
    end
    fault = 1'b0; hold(CF + 4);
    finish_run();
  end
endmodule